// File: doc/BRIEF.md
# Command/Response Buffer Control Registers

This block is the memory-mapped register front end of a trusted-module command/response buffer interface. A host reaches it over a simple little-endian register bus with accesses of one to four bytes. The block identifies itself through a read-only capability word, lets the host claim its single locality, and moves the control status between ready and idle. It advertises where the command and response buffers sit and how large they are.

The host places a command in the data buffer and then rings the start doorbell. The block raises a one-cycle request to the backend command processor. With that request it passes the command length, clamped to the usable buffer size, and the response capacity. A cancel doorbell forwards a one-cycle cancel only while a command is outstanding. When the backend signals completion, the start flag drops, and an error on that completion latches a fatal flag. The data buffer memory and the command processor are outside the block and appear only as handshake ports.

Top module: `cmdbuf_regs`

## Requirements
- R1: `hst_rdata` combinationally returns the aligned 32-bit word at `hst_addr` shifted right by 8 times `hst_addr[1:0]`, whatever the access size. Unmapped offsets and the write-only words read as zero. The write-only words are locality control at 0x08, control request at 0x40 and cancel at 0x48.
- R2: A write with `hst_size` = bytes-1 merges only the addressed byte lanes, from `hst_addr[1:0]` upward and within the word, into the target value. `hst_wdata` is taken from its least significant byte. Lanes past the word end are dropped.
- R3: After reset, the identification word at 0x30 reads type[3:0]=1, version[7:4]=1, locality-0-only[8]=0, idle bypass[9]=0, transfer size[12:11]=3, FIFO[13]=0, buffer interface[14]=1 and selector[18:17]=1. All other bits read zero.
- R4: Command size at 0x58 and response size at 0x64 both read WIN_BYTES-DBUF_OFF. Command address at 0x5C and response address at 0x68 both read WIN_BASE+DBUF_OFF.
- R5: Writes to the identification, size and address words are ignored.
- R6: A write whose merged value is exactly 1 to the start word at 0x4C sets start bit 0 when it is clear. In the cycle after that write edge, `be_req` is high for one cycle. Any other value, and any write while the bit is set, has no effect.
- R7: With `be_req`, `be_cmd_len` is the smaller of `be_hdr_len` and BUF = min(BE_BUF_BYTES, WIN_BYTES-DBUF_OFF), and `be_rsp_len` is BUF.
- R8: A merged value of exactly 1 written to the cancel word at 0x48 while the start bit is set pulses `be_cancel` for one cycle after the write edge. Otherwise the write has no effect.
- R9: `be_done` clears the start bit at that edge. If `be_err` is high with it, fatal bit 0 of the control status word at 0x44 sets and stays set until reset.
- R10: A control request value of exactly 1 clears idle bit 1 of 0x44, and exactly 2 sets it. Any other value is ignored. Idle resets to 0.
- R11: A locality control value of exactly 1 sets the granted bit 0 of locality status at 0x0C and the assigned bit 1 of locality state at 0x00. Locality state bit 7 always reads 1. Values 2, 4 and 8 (relinquish, seize, clear establishment) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_valid | input | 1 | Host access valid |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Byte address within the window |
| hst_size | input | 2 | Access size in bytes minus one |
| hst_wdata | input | 32 | Write data, least significant byte first |
| hst_rdata | output | 32 | Read data, shifted by byte offset |
| be_hdr_len | input | 32 | Length field from the command header |
| be_req | output | 1 | One-cycle command request to backend |
| be_cmd_len | output | 32 | Clamped command length |
| be_rsp_len | output | 32 | Response capacity |
| be_cancel | output | 1 | One-cycle cancel to backend |
| be_done | input | 1 | Backend completion |
| be_err | input | 1 | Completion carries an error |

## Verification
The read path is swept over every byte offset and every access size on the identification word. Agreement with the arithmetic shift shows that the offset is applied and that the size is not. The start doorbell is rung with a one-byte value of 1 at each of the four lanes and with a halfword at lane 0. Only lane 0 may fire, which separates true lane merging from a check of the raw bus data. Header lengths below and above the buffer size separate the clamp from a pass-through. Cancel, completion with and without error, the exact-value control and locality codes, and writes to read-only words are each driven in both the state where they act and the state where they must not.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    // Word offsets decoded by host software
    localparam logic [7:0] OFS_LOC_STATE = 8'h00;
    localparam logic [7:0] OFS_LOC_CTRL  = 8'h08;
    localparam logic [7:0] OFS_LOC_STS   = 8'h0C;
    localparam logic [7:0] OFS_IDENT     = 8'h30;
    localparam logic [7:0] OFS_CTL_REQ   = 8'h40;
    localparam logic [7:0] OFS_CTL_STS   = 8'h44;
    localparam logic [7:0] OFS_CANCEL    = 8'h48;
    localparam logic [7:0] OFS_START     = 8'h4C;
    localparam logic [7:0] OFS_CMD_SIZE  = 8'h58;
    localparam logic [7:0] OFS_CMD_ADDR  = 8'h5C;
    localparam logic [7:0] OFS_RSP_SIZE  = 8'h64;
    localparam logic [7:0] OFS_RSP_ADDR  = 8'h68;

    // Exact request codes
    localparam logic [31:0] CODE_ONE = 32'd1;
    localparam logic [31:0] CODE_TWO = 32'd2;

    // Capability word fields
    localparam logic [3:0] ID_TYPE_ACTIVE = 4'd1;
    localparam logic [3:0] ID_VERSION     = 4'd1;
    localparam logic       ID_LOC0_ONLY   = 1'b0;
    localparam logic       ID_IDLE_BYP    = 1'b0;
    localparam logic [1:0] ID_XFER_64     = 2'b11;
    localparam logic       ID_FIFO        = 1'b0;
    localparam logic       ID_BUF_IF      = 1'b1;
    localparam logic [1:0] ID_SELECT      = 2'b01;

    typedef struct packed {
        logic assigned;
        logic granted;
        logic idle;
    } ctl_state_t;

    typedef struct packed {
        logic        start;
        logic        fatal;
        logic        req;
        logic        cancel;
        logic [31:0] cmd_len;
    } bell_state_t;

    function automatic logic [31:0] ident_word();
        logic [31:0] w;
        w        = '0;
        w[3:0]   = ID_TYPE_ACTIVE;
        w[7:4]   = ID_VERSION;
        w[8]     = ID_LOC0_ONLY;
        w[9]     = ID_IDLE_BYP;
        w[12:11] = ID_XFER_64;
        w[13]    = ID_FIFO;
        w[14]    = ID_BUF_IF;
        w[18:17] = ID_SELECT;
        return w;
    endfunction

endpackage

// File: rtl/cmdbuf_wr_lanes.sv
module cmdbuf_wr_lanes #(
    parameter int unsigned LANES = 4
) (
    input  logic [1:0]           byte_ofs,
    input  logic [1:0]           size_m1,
    input  logic [LANES*8-1:0]   wdata,
    input  logic [LANES*8-1:0]   old_word,
    output logic [LANES*8-1:0]   merged,
    output logic [LANES-1:0]     lane_en
);
    localparam int unsigned W = LANES * 8;

    logic [W-1:0] shifted;

    assign shifted = wdata << {byte_ofs, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            lane_en[i] = (i >= int'(byte_ofs)) &&
                         (i <= int'(byte_ofs) + int'(size_m1));
            merged[i*8 +: 8] = lane_en[i] ? shifted[i*8 +: 8]
                                          : old_word[i*8 +: 8];
        end
    end

    // R2
    always_comb begin
        lane_sel_chk: assert (lane_en != '0);
    end

endmodule

// File: rtl/cmdbuf_rd_align.sv
module cmdbuf_rd_align #(
    parameter int unsigned LANES = 4
) (
    input  logic [1:0]           byte_ofs,
    input  logic [LANES*8-1:0]   word,
    output logic [LANES*8-1:0]   rdata
);
    assign rdata = word >> {byte_ofs, 3'b000};
endmodule

// File: rtl/cmdbuf_doorbell.sv
module cmdbuf_doorbell
    import cmdbuf_pkg::*;
#(
    parameter logic [31:0] BUF_BYTES = 32'h800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_wr,
    input  logic        cancel_wr,
    input  logic [31:0] wr_val,
    input  logic [31:0] hdr_len,
    input  logic        done,
    input  logic        err,
    output logic        start_o,
    output logic        fatal_o,
    output logic        req_o,
    output logic [31:0] cmd_len_o,
    output logic [31:0] rsp_len_o,
    output logic        cancel_o
);
    bell_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d        = st_q;
        st_d.req    = 1'b0;
        st_d.cancel = 1'b0;
        fire        = start_wr && (wr_val == CODE_ONE) && !st_q.start;
        if (fire) begin
            st_d.start   = 1'b1;
            st_d.req     = 1'b1;
            st_d.cmd_len = (hdr_len < BUF_BYTES) ? hdr_len : BUF_BYTES;
        end else if (done) begin
            st_d.start = 1'b0;
        end
        if (done && err) begin
            st_d.fatal = 1'b1;
        end
        if (cancel_wr && (wr_val == CODE_ONE) && st_q.start) begin
            st_d.cancel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o   = st_q.start;
    assign fatal_o   = st_q.fatal;
    assign req_o     = st_q.req;
    assign cmd_len_o = st_q.cmd_len;
    assign rsp_len_o = BUF_BYTES;
    assign cancel_o  = st_q.cancel;

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R6
    req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (start_o && !$past(start_o)));
    // R7
    len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (cmd_len_o <= BUF_BYTES));
    // R8
    cancel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> $past(start_o));
    // R9
    fatal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |=> fatal_o);
    // R9
    fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> fatal_o);
    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_wr) |=> !start_o);

endmodule

// File: rtl/cmdbuf_regs.sv
module cmdbuf_regs
    import cmdbuf_pkg::*;
#(
    parameter int unsigned WIN_BYTES    = 4096,
    parameter int unsigned DBUF_OFF     = 128,
    parameter logic [31:0] WIN_BASE     = 32'hFED4_0000,
    parameter int unsigned BE_BUF_BYTES = 2048,
    parameter int unsigned ADDR_W       = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_valid,
    input  logic              hst_write,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [1:0]        hst_size,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    input  logic [31:0]       be_hdr_len,
    output logic              be_req,
    output logic [31:0]       be_cmd_len,
    output logic [31:0]       be_rsp_len,
    output logic              be_cancel,
    input  logic              be_done,
    input  logic              be_err
);
    localparam logic [31:0] CMD_BYTES = 32'(WIN_BYTES - DBUF_OFF);
    localparam logic [31:0] BUF_BYTES = (32'(BE_BUF_BYTES) < CMD_BYTES) ?
                                        32'(BE_BUF_BYTES) : CMD_BYTES;
    localparam logic [31:0] BUF_ADDR  = WIN_BASE + 32'(DBUF_OFF);
    localparam logic [31:0] IDENT     = ident_word();

    ctl_state_t  ctl_d, ctl_q;
    logic [31:0] word_sel;
    logic [31:0] merged;
    logic [3:0]  lane_en;
    logic        wr_en;
    logic        in_regs;
    logic [7:0]  wofs;
    logic        start_bit;
    logic        fatal_bit;

    assign wr_en   = hst_valid && hst_write;
    assign in_regs = (hst_addr >> 8) == '0;
    assign wofs    = {hst_addr[7:2], 2'b00};

    // Aligned word selected by the address
    always_comb begin
        word_sel = '0;
        if (in_regs) begin
            unique case (wofs)
                OFS_LOC_STATE: word_sel = {24'd0, 1'b1, 5'd0, ctl_q.assigned, 1'b0};
                OFS_LOC_STS:   word_sel = {31'd0, ctl_q.granted};
                OFS_IDENT:     word_sel = IDENT;
                OFS_CTL_STS:   word_sel = {30'd0, ctl_q.idle, fatal_bit};
                OFS_START:     word_sel = {31'd0, start_bit};
                OFS_CMD_SIZE:  word_sel = CMD_BYTES;
                OFS_CMD_ADDR:  word_sel = BUF_ADDR;
                OFS_RSP_SIZE:  word_sel = CMD_BYTES;
                OFS_RSP_ADDR:  word_sel = BUF_ADDR;
                default:       word_sel = '0;
            endcase
        end
    end

    cmdbuf_rd_align #(.LANES(4)) u_rd (
        .byte_ofs (hst_addr[1:0]),
        .word     (word_sel),
        .rdata    (hst_rdata)
    );

    cmdbuf_wr_lanes #(.LANES(4)) u_wr (
        .byte_ofs (hst_addr[1:0]),
        .size_m1  (hst_size),
        .wdata    (hst_wdata),
        .old_word (word_sel),
        .merged   (merged),
        .lane_en  (lane_en)
    );

    cmdbuf_doorbell #(.BUF_BYTES(BUF_BYTES)) u_bell (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (wr_en && in_regs && (wofs == OFS_START)),
        .cancel_wr (wr_en && in_regs && (wofs == OFS_CANCEL)),
        .wr_val    (merged),
        .hdr_len   (be_hdr_len),
        .done      (be_done),
        .err       (be_err),
        .start_o   (start_bit),
        .fatal_o   (fatal_bit),
        .req_o     (be_req),
        .cmd_len_o (be_cmd_len),
        .rsp_len_o (be_rsp_len),
        .cancel_o  (be_cancel)
    );

    // Next state of locality and control status
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && in_regs) begin
            if (wofs == OFS_LOC_CTRL && merged == CODE_ONE) begin
                ctl_d.granted  = 1'b1;
                ctl_d.assigned = 1'b1;
            end
            if (wofs == OFS_CTL_REQ) begin
                if (merged == CODE_ONE) begin
                    ctl_d.idle = 1'b0;
                end else if (merged == CODE_TWO) begin
                    ctl_d.idle = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R11
    loc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.granted |=> ctl_q.granted);
    // R11
    loc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.granted == ctl_q.assigned);
    // R10
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.idle) |-> $past(wr_en && wofs == OFS_CTL_REQ));
    // R7
    rsp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> (be_rsp_len == BUF_BYTES));

endmodule

// File: tb/tb_cmdbuf_regs.sv
module tb_cmdbuf_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_valid = 1'b0;
    logic        hst_write = 1'b0;
    logic [11:0] hst_addr = '0;
    logic [1:0]  hst_size = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic [31:0] be_hdr_len = '0;
    logic        be_req;
    logic [31:0] be_cmd_len;
    logic [31:0] be_rsp_len;
    logic        be_cancel;
    logic        be_done = 1'b0;
    logic        be_err = 1'b0;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    localparam logic [31:0] WIN  = 32'd4096;
    localparam logic [31:0] OFF  = 32'd128;
    localparam logic [31:0] BASE = 32'hFED4_0000;
    localparam logic [31:0] BUF  = 32'd2048;

    always #2.5 clk = ~clk;

    cmdbuf_regs dut (
        .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
        .hst_addr(hst_addr), .hst_size(hst_size), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .be_hdr_len(be_hdr_len), .be_req(be_req),
        .be_cmd_len(be_cmd_len), .be_rsp_len(be_rsp_len), .be_cancel(be_cancel),
        .be_done(be_done), .be_err(be_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive at negedge, commit on next posedge, return at following negedge
    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        hst_valid = 1'b1; hst_write = 1'b1; hst_addr = a; hst_size = sz; hst_wdata = d;
        @(negedge clk);
        hst_valid = 1'b0; hst_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        hst_valid = 1'b1; hst_write = 1'b0; hst_addr = a; hst_size = sz;
        #1 d = hst_rdata;
        hst_valid = 1'b0;
    endtask

    task automatic pulse_done(input logic e);
        @(negedge clk);
        be_done = 1'b1; be_err = e;
        @(negedge clk);
        be_done = 1'b0; be_err = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] id;
        id = 32'd1 | (32'd1 << 4) | (32'd3 << 11) | (32'd1 << 14) | (32'd1 << 17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 sweep offsets and sizes on identification word
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 4; s++) begin
                rd(12'h030 + 12'(o), 2'(s), v);
                chk("R1_R3 ident shift", v, id >> (8 * o));
            end
        end
        // R4
        rd(12'h058, 2'd3, v); chk("R4 cmd size", v, WIN - OFF);
        rd(12'h064, 2'd3, v); chk("R4 rsp size", v, WIN - OFF);
        rd(12'h05C, 2'd3, v); chk("R4 cmd addr", v, BASE + OFF);
        rd(12'h06A, 2'd1, v); chk("R4 rsp addr hi", v, (BASE + OFF) >> 16);
        // R1 unmapped and write-only
        rd(12'h010, 2'd3, v); chk("R1 unmapped", v, 0);
        rd(12'h0F0, 2'd3, v); chk("R1 unmapped high", v, 0);
        rd(12'h048, 2'd3, v); chk("R1 cancel reads zero", v, 0);
        // reset state
        rd(12'h044, 2'd3, v); chk("R10 reset ctl status", v, 0);
        rd(12'h000, 2'd3, v); chk("R11 reset loc state", v, 32'h80);
        rd(12'h00C, 2'd3, v); chk("R11 reset loc status", v, 0);
        rd(12'h04C, 2'd3, v); chk("R6 reset start", v, 0);
        // R5
        wr(12'h030, 2'd3, 32'h0);
        rd(12'h030, 2'd3, v); chk("R5 ident write ignored", v, id);
        wr(12'h058, 2'd3, 32'h12);
        rd(12'h058, 2'd3, v); chk("R5 size write ignored", v, WIN - OFF);
        // R8 cancel while idle
        wr(12'h048, 2'd3, 32'd1);
        chk("R8 cancel idle no pulse", be_cancel, 0);
        // R2 R6 byte of 1 on upper lanes must not fire
        for (int o = 1; o < 4; o++) begin
            wr(12'h04C + 12'(o), 2'd0, 32'd1);
            chk("R2_R6 upper lane no req", be_req, 0);
            rd(12'h04C, 2'd3, v); chk("R2_R6 upper lane start clear", v, 0);
        end
        // R6 R7 fire on lane 0 with short header
        be_hdr_len = 32'h100;
        wr(12'h04C, 2'd0, 32'hFFFF_FF01);
        chk("R6 req pulse", be_req, 1);
        chk("R7 cmd len short", be_cmd_len, 32'h100);
        chk("R7 rsp len", be_rsp_len, BUF);
        @(negedge clk);
        chk("R6 req single", be_req, 0);
        rd(12'h04C, 2'd3, v); chk("R6 start set", v, 1);
        // R6 while set ignored
        wr(12'h04C, 2'd3, 32'd1);
        chk("R6 busy no req", be_req, 0);
        // R8 cancel in flight; non-1 value ignored
        wr(12'h048, 2'd3, 32'd3);
        chk("R8 cancel other value", be_cancel, 0);
        wr(12'h048, 2'd0, 32'd1);
        chk("R8 cancel pulse", be_cancel, 1);
        @(negedge clk);
        chk("R8 cancel single", be_cancel, 0);
        // R9 done clears, no error
        pulse_done(1'b0);
        rd(12'h04C, 2'd3, v); chk("R9 done clears start", v, 0);
        rd(12'h044, 2'd3, v); chk("R9 no fatal", v, 0);
        // R7 long header, halfword start
        be_hdr_len = 32'h5000;
        wr(12'h04C, 2'd1, 32'h0001);
        chk("R6 halfword fires", be_req, 1);
        chk("R7 cmd len clamped", be_cmd_len, BUF);
        // R9 error completion
        pulse_done(1'b1);
        rd(12'h044, 2'd3, v); chk("R9 fatal set", v, 1);
        rd(12'h04C, 2'd3, v); chk("R9 start cleared", v, 0);
        wr(12'h04C, 2'd3, 32'd1);
        pulse_done(1'b0);
        rd(12'h044, 2'd0, v); chk("R9 fatal sticky", v, 1);
        // R10
        wr(12'h040, 2'd3, 32'd2);
        rd(12'h044, 2'd3, v); chk("R10 go idle", v, 3);
        wr(12'h040, 2'd3, 32'd3);
        rd(12'h044, 2'd3, v); chk("R10 value 3 ignored", v, 3);
        wr(12'h040, 2'd3, 32'd1);
        rd(12'h044, 2'd3, v); chk("R10 cmd ready", v, 1);
        // R11
        for (int k = 1; k < 4; k++) begin
            wr(12'h008, 2'd3, 32'd1 << k);
            rd(12'h00C, 2'd3, v); chk("R11 other code no grant", v, 0);
        end
        wr(12'h008, 2'd3, 32'd1);
        rd(12'h00C, 2'd3, v); chk("R11 granted", v, 1);
        rd(12'h000, 2'd3, v); chk("R11 assigned", v, 32'h82);
        rd(12'h008, 2'd3, v); chk("R1 loc ctrl reads zero", v, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule